// File: doc/BRIEF.md
# Hash Engine Interrupt Merger

This block joins the event pulses of a hash core and of the DMA engine that feeds it into a single level interrupt. Each source has its own bank: a sticky status register that is cleared by writing ones and an enable register that picks which pending bits may raise the line. The DMA bank also passes through one global gate bit. The block also reports whether the line is raised by a completion event or by an error event, so a handler can tell the two apart without decoding both banks.

Software writes through a plain one-cycle write strobe with a 3-bit register select. Status is observed directly on output pins. There is no streaming data path, so no valid/ready handshake is used. Every pin is a plain control or status signal, sampled or updated on the rising clock edge.

Register select encoding: 0 = hash status (write-one-to-clear), 1 = hash enable, 2 = DMA status (write-one-to-clear), 3 = DMA enable, 4 = DMA gate (bit 0 only). Selects 5 to 7 are unused.

Top module: `hash_irq_merge`

## Requirements
- R1: While reset is held and immediately after it, both status registers, both enable registers and the DMA gate are zero, and `irq_o`, `done_o` and `err_o` are low.
- R2: A pulse on `hash_evt_i[n]` sets hash status bit n on the next rising edge, whatever the enables hold. Bit 2 is the done event. Bits 0, 1 and 3 are error events.
- R3: A pulse on `dma_evt_i[n]` sets DMA status bit n on the next edge, whatever the enables or the gate hold. Bit 0 is the source-transfer-done event. Bits 2 through 8 are errors. Bit 1 is reserved and never becomes set.
- R4: A write to select 0 or 2 clears exactly the status bits whose data bit is 1 and leaves every other bit unchanged. Writing all ones clears the whole bank.
- R5: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq_o` is the OR of (hash status AND hash enable) and, when the gate is 1, of (DMA status AND DMA enable). It follows register changes with no added cycle of delay. A bank whose enable is written 0 cannot raise the line.
- R7: While DMA gate bit 0 is 0, DMA status cannot raise `irq_o` but still latches. Setting the gate to 1 with an enabled bit already pending raises the line.
- R8: `done_o` is high when an enabled and ungated done bit (hash bit 2 or DMA bit 0) is pending. `err_o` is high when an enabled and ungated error bit is pending.
- R9: Writes with select 5, 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_evt_i | input | 4 | Hash core event pulses, one per status bit |
| dma_evt_i | input | 9 | DMA event pulses, one per status bit |
| cfg_we_i | input | 1 | Register write strobe, one cycle per write |
| cfg_sel_i | input | 3 | Register select (encoding above) |
| cfg_wdata_i | input | DATA_W | Write data, low bits used |
| hash_stat_o | output | 4 | Hash status register |
| dma_stat_o | output | 9 | DMA status register |
| irq_o | output | 1 | Merged level interrupt |
| done_o | output | 1 | A passing done event is pending |
| err_o | output | 1 | A passing error event is pending |

## Verification
An incoming event and a software clear can land on the same status bit in one cycle. This is the collision that decides whether a completion is lost. The bench forces it by asserting an event pulse and a write-one-to-clear strobe in the same cycle, once on a bit that is already set and once on a bit that is clear. In the same write it also clears a second pending bit that has no new event. The bench then judges the status one cycle later: the colliding bit must read 1 and the other cleared bit must read 0.

// File: rtl/hash_irq_pkg.sv
package hash_irq_pkg;

  localparam int HASH_BITS = 4;
  localparam int DMA_BITS  = 9;

  typedef enum logic [2:0] {
    SEL_HASH_STAT = 3'd0,
    SEL_HASH_EN   = 3'd1,
    SEL_DMA_STAT  = 3'd2,
    SEL_DMA_EN    = 3'd3,
    SEL_DMA_GATE  = 3'd4
  } cfg_sel_e;

  localparam logic [HASH_BITS-1:0] HASH_DONE_M  = 4'b0100;
  localparam logic [HASH_BITS-1:0] HASH_ERR_M   = 4'b1011;
  localparam logic [HASH_BITS-1:0] HASH_VALID_M = HASH_DONE_M | HASH_ERR_M;

  localparam logic [DMA_BITS-1:0]  DMA_DONE_M   = 9'h001;
  localparam logic [DMA_BITS-1:0]  DMA_ERR_M    = 9'h1FC;
  localparam logic [DMA_BITS-1:0]  DMA_VALID_M  = DMA_DONE_M | DMA_ERR_M;

endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int           W       = 4,
  parameter logic [W-1:0] VALID_M = '1,
  parameter logic [W-1:0] DONE_M  = '0,
  parameter logic [W-1:0] ERR_M   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic         done_pend_o,
  output logic         err_pend_o
);

  logic [W-1:0] st_q, en_q, clr_vec, st_d, pend;

  assign clr_vec = clr_we_i ? wdata_i : '0;
  // an event wins over a clear of the same bit
  assign st_d    = ((st_q & ~clr_vec) | evt_i) & VALID_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      if (en_we_i) en_q <= wdata_i & VALID_M;
    end
  end

  assign pend        = st_q & en_q;
  assign stat_o      = st_q;
  assign done_pend_o = |(pend & DONE_M);
  assign err_pend_o  = |(pend & ERR_M);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(st_q) & ~$past(clr_vec) & ~st_q) == '0));

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(evt_i & VALID_M)) == $past(evt_i & VALID_M)));

  // R4
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(clr_vec & ~evt_i)) == '0));

endmodule

// File: rtl/irq_merge_or.sv
module irq_merge_or (
  input  logic h_done_i,
  input  logic h_err_i,
  input  logic d_done_i,
  input  logic d_err_i,
  input  logic d_gate_i,
  output logic done_o,
  output logic err_o,
  output logic irq_o
);

  logic d_done_g, d_err_g;

  assign d_done_g = d_done_i & d_gate_i;
  assign d_err_g  = d_err_i  & d_gate_i;
  assign done_o   = h_done_i | d_done_g;
  assign err_o    = h_err_i  | d_err_g;
  assign irq_o    = done_o | err_o;

endmodule

// File: rtl/hash_irq_merge.sv
module hash_irq_merge
  import hash_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HASH_BITS-1:0] hash_evt_i,
  input  logic [DMA_BITS-1:0]  dma_evt_i,
  input  logic                 cfg_we_i,
  input  logic [2:0]           cfg_sel_i,
  input  logic [DATA_W-1:0]    cfg_wdata_i,
  output logic [HASH_BITS-1:0] hash_stat_o,
  output logic [DMA_BITS-1:0]  dma_stat_o,
  output logic                 irq_o,
  output logic                 done_o,
  output logic                 err_o
);

  logic h_clr_we, h_en_we, d_clr_we, d_en_we, gate_we;
  logic gate_q;
  logic h_done, h_err, d_done, d_err;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata_i[DATA_W-1:DMA_BITS];

  always_comb begin
    h_clr_we = 1'b0;
    h_en_we  = 1'b0;
    d_clr_we = 1'b0;
    d_en_we  = 1'b0;
    gate_we  = 1'b0;
    if (cfg_we_i) begin
      case (cfg_sel_e'(cfg_sel_i))
        SEL_HASH_STAT: h_clr_we = 1'b1;
        SEL_HASH_EN:   h_en_we  = 1'b1;
        SEL_DMA_STAT:  d_clr_we = 1'b1;
        SEL_DMA_EN:    d_en_we  = 1'b1;
        SEL_DMA_GATE:  gate_we  = 1'b1;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (gate_we) gate_q <= cfg_wdata_i[0];
  end

  irq_w1c_bank #(
    .W(HASH_BITS), .VALID_M(HASH_VALID_M), .DONE_M(HASH_DONE_M), .ERR_M(HASH_ERR_M)
  ) u_hash_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(hash_evt_i),
    .clr_we_i(h_clr_we), .en_we_i(h_en_we), .wdata_i(cfg_wdata_i[HASH_BITS-1:0]),
    .stat_o(hash_stat_o), .done_pend_o(h_done), .err_pend_o(h_err)
  );

  irq_w1c_bank #(
    .W(DMA_BITS), .VALID_M(DMA_VALID_M), .DONE_M(DMA_DONE_M), .ERR_M(DMA_ERR_M)
  ) u_dma_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(dma_evt_i),
    .clr_we_i(d_clr_we), .en_we_i(d_en_we), .wdata_i(cfg_wdata_i[DMA_BITS-1:0]),
    .stat_o(dma_stat_o), .done_pend_o(d_done), .err_pend_o(d_err)
  );

  irq_merge_or u_merge (
    .h_done_i(h_done), .h_err_i(h_err), .d_done_i(d_done), .d_err_i(d_err),
    .d_gate_i(gate_q), .done_o(done_o), .err_o(err_o), .irq_o(irq_o)
  );

  // R7
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && !h_done && !h_err) |-> !irq_o);

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (h_done || h_err || d_done || d_err));

  // R3
  dma_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt_i[1] |=> !dma_stat_o[1]);

endmodule

// File: tb/hash_irq_merge_bench.sv
`timescale 1ns/1ps
module hash_irq_merge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hash_evt = '0;
  logic [8:0]  dma_evt = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  hash_stat;
  logic [8:0]  dma_stat;
  logic        irq, done, err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hash_irq_merge u_hash_irq_merge (
    .clk(clk), .rst_n(rst_n), .hash_evt_i(hash_evt), .dma_evt_i(dma_evt),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .hash_stat_o(hash_stat), .dma_stat_o(dma_stat),
    .irq_o(irq), .done_o(done), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; results visible at the following negedge
  task automatic cyc(input logic we, input logic [2:0] sel, input logic [31:0] d,
                     input logic [3:0] he, input logic [8:0] de);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d; hash_evt = he; dma_evt = de;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0; hash_evt = '0; dma_evt = '0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    cyc(1'b1, sel, d, 4'h0, 9'h0);
  endtask

  task automatic clear_all();
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk("R1 hash status", {28'h0, hash_stat}, 32'h0);
    chk("R1 dma status", {23'h0, dma_stat}, 32'h0);
    chk("R1 irq/done/err", {29'h0, irq, done, err}, 32'h0);
    cyc(1'b0, 3'd0, 0, 4'h4, 9'h001);
    chk("R1 enables zero", {31'h0, irq}, 32'h0);
    clear_all();
  endtask

  task automatic t_hash_latch();
    cyc(1'b0, 3'd0, 0, 4'b0101, 9'h0);
    chk("R2 hash latch", {28'h0, hash_stat}, 32'h5);
    chk("R2 no irq when disabled", {31'h0, irq}, 32'h0);
    cyc(1'b0, 3'd0, 0, 4'b1000, 9'h0);
    chk("R2 hash accumulate", {28'h0, hash_stat}, 32'hD);
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R4 all ones clears hash", {28'h0, hash_stat}, 32'h0);
  endtask

  task automatic t_dma_latch();
    cyc(1'b0, 3'd0, 0, 4'h0, 9'h1FF);
    chk("R3 dma latch, bit1 reserved", {23'h0, dma_stat}, 32'h1FD);
    wr(3'd2, 32'h005);
    chk("R4 partial clear", {23'h0, dma_stat}, 32'h1F8);
    wr(3'd2, 32'hFFFF_FFFF);
    chk("R4 all ones clears dma", {23'h0, dma_stat}, 32'h0);
  endtask

  task automatic t_collide();
    cyc(1'b0, 3'd0, 0, 4'b1001, 9'h0);
    chk("R5 preset", {28'h0, hash_stat}, 32'h9);
    cyc(1'b1, 3'd0, 32'h9, 4'b0001, 9'h0);
    chk("R5 event beats clear", {28'h0, hash_stat}, 32'h1);
    cyc(1'b1, 3'd2, 32'h10, 4'h0, 9'h010);
    chk("R5 event on clear bit in dma", {23'h0, dma_stat}, 32'h010);
    clear_all();
  endtask

  task automatic t_enable();
    wr(3'd1, 32'h4);
    cyc(1'b0, 3'd0, 0, 4'b0001, 9'h0);
    chk("R6 disabled bit no irq", {31'h0, irq}, 32'h0);
    cyc(1'b0, 3'd0, 0, 4'b0100, 9'h0);
    chk("R6 enabled done raises irq", {29'h0, irq, done, err}, 32'h6);
    wr(3'd1, 32'h0);
    chk("R6 enable 0 suppresses", {31'h0, irq}, 32'h0);
    chk("R6 status kept", {28'h0, hash_stat}, 32'h5);
    clear_all();
  endtask

  task automatic t_gate();
    wr(3'd3, 32'h1FD);
    cyc(1'b0, 3'd0, 0, 4'h0, 9'h004);
    chk("R7 gate closed no irq", {31'h0, irq}, 32'h0);
    chk("R7 status latched", {23'h0, dma_stat}, 32'h004);
    wr(3'd4, 32'h1);
    chk("R8 gate open err", {29'h0, irq, done, err}, 32'h5);
    wr(3'd4, 32'h0);
    chk("R7 gate closed again", {31'h0, irq}, 32'h0);
    wr(3'd4, 32'h1);
    wr(3'd2, 32'h4);
    chk("R6 clear drops irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_classify();
    wr(3'd1, 32'hF);
    cyc(1'b0, 3'd0, 0, 4'h0, 9'h001);
    chk("R8 dma done only", {29'h0, irq, done, err}, 32'h6);
    cyc(1'b0, 3'd0, 0, 4'h8, 9'h0);
    chk("R8 done and err", {29'h0, irq, done, err}, 32'h7);
    wr(3'd0, 32'hF);
    chk("R8 err cleared", {29'h0, irq, done, err}, 32'h6);
    clear_all();
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0);
  endtask

  task automatic t_bad_sel();
    cyc(1'b0, 3'd0, 0, 4'h4, 9'h101);
    for (int s = 5; s < 8; s++) wr(s[2:0], 32'hFFFF_FFFF);
    chk("R9 hash status unchanged", {28'h0, hash_stat}, 32'h4);
    chk("R9 dma status unchanged", {23'h0, dma_stat}, 32'h101);
    chk("R9 enables unchanged", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h100);
    chk("R9 gate unchanged", {31'h0, irq}, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      chk("R1 in reset", {19'h0, hash_stat, dma_stat}, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hash_latch();
    t_dma_latch();
    t_collide();
    t_enable();
    t_gate();
    t_classify();
    t_bad_sel();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule